// File: doc/BRIEF.md
# Clocked Sequencer for a 16-bit Asynchronous Static RAM

This block sits between a synchronous host and an asynchronous static memory that is 16 bits wide, with separate strobes for the high and low byte lanes. The host posts one request at a time: a word address of 20 bits, a direction flag, a two-bit lane mask and the data to store. It holds the request until the block returns a one-cycle ready pulse. On a read, the returned word arrives together with that pulse.

On the memory side every pin comes from a flop. Each access runs through four phases: an address setup cycle with all strobes inactive, an active phase with chip select and the chosen lane strobes asserted, a recovery phase with the strobes released, and a return to idle. The lengths of the active and recovery phases come from nanosecond parameters and the clock period. Each one is a ceiling division with a floor of one cycle, so the same RTL serves any speed grade once its figures are plugged in. A lane mask of zero is answered at once and never touches the memory.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, write enable, output enable and both lane strobes are high (inactive), the data-bus drive enable is low and ready is low.
- R2: A write with a nonzero mask holds write enable low for exactly WR_ACT cycles. WR_ACT is the larger of ceil(write pulse / clock) and ceil(data setup / clock), which is 6 at the defaults. Chip select is low during that time, and output enable stays high. The upper strobe (data bits 15:8) is low exactly when mask bit 1 is set, and the lower strobe (bits 7:0) exactly when mask bit 0 is set.
- R3: The memory address is set to the request address at least one cycle before chip select falls. It does not change while chip select is low.
- R4: The data-bus drive enable is high exactly in the cycles where write enable is low, and the driven word equals the request's write data.
- R5: A read with a nonzero mask holds output enable and chip select low, with write enable high, for exactly RD_ACT cycles. RD_ACT is the larger of ceil(address access / clock) and ceil(output-enable access / clock), which is 9 at the defaults. The returned word is the bus value sampled on the clock edge that ends this phase, with the byte lanes not selected by the mask forced to zero.
- R6: With the request raised just after a clock edge, ready becomes visible after 2 + WR_ACT + WR_REC edges for a write and 2 + RD_ACT + RD_REC edges for a read. WR_REC = max(ceil(write recovery / clock), ceil(write cycle / clock) − 1 − WR_ACT) and RD_REC = max(1, ceil(read cycle / clock) − 1 − RD_ACT). At the defaults this gives 10 edges for a write and 12 for a read.
- R7: Ready is high for exactly one cycle per request.
- R8: A request with mask 2'b00 raises ready after one edge and leaves chip select and every other strobe high.
- R9: Between two accesses, chip select is high for at least one cycle, and it is high in the cycle before it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request valid; held until host_rdy |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Lane mask, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| host_addr | input | 20 | Word address |
| host_wdata | input | 16 | Write data |
| host_rdy | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_rdy |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a partial write landing on a word that already holds data in the other lane, followed by a read that selects only some of the lanes. An off-by-one in lane handling shows up only in that combination. The bench therefore draws addresses from a pool of sixteen words, so random writes with every mask overlap often. Directed single-lane writes and reads on the same word come first. Mask-zero requests of both directions are mixed into the random traffic, to check that they never pull a strobe.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_RECOV = 2'd3
  } phase_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len - CW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            nxt_phase,
  input  logic              cmd_we,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic act;
  assign act = (nxt_phase == PH_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      cs_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (addr_load) addr <= addr_in;
      cs_n  <= !act;
      we_n  <= !(act && cmd_we);
      oe_n  <= !(act && !cmd_we);
      dq_oe <= act && cmd_we;
      if (act && cmd_we) dq_out <= cmd_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) lane_n[g] <= 1'b1;
      else     lane_n[g] <= !(act && cmd_be[g]);
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int T_WC_NS = 85,
  parameter int T_WP_NS = 55,
  parameter int T_WR_NS = 5,
  parameter int T_DW_NS = 35,
  parameter int T_RC_NS = 85,
  parameter int T_AA_NS = 85,
  parameter int T_OE_NS = 45
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [1:0]        host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rdy,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int WR_ACT = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int WR_REC = imax(ns_to_cyc(T_WR_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS) - 1 - WR_ACT);
  localparam int RD_ACT = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int RD_REC = imax(1, ns_to_cyc(T_RC_NS, CLK_NS) - 1 - RD_ACT);
  localparam int MAXC   = imax(imax(WR_ACT, WR_REC), imax(RD_ACT, RD_REC));
  localparam int CW     = $clog2(MAXC + 1);

  phase_e             ph_q, ph_d;
  logic               cmd_we_q;
  logic [LANES-1:0]   cmd_be_q;
  logic [DATA_W-1:0]  cmd_wdata_q;
  logic               rdy_q, rdy_d;
  logic [DATA_W-1:0]  rdata_q;
  logic               t_load, t_last;
  logic [CW-1:0]      t_len;
  logic               accept, empty_mask, start;
  logic [LANES-1:0]   lane_n;

  assign accept     = (ph_q == PH_IDLE) && host_req && !rdy_q;
  assign empty_mask = (host_be == '0);
  assign start      = accept && !empty_mask;

  always_comb begin
    ph_d  = ph_q;
    rdy_d = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) ph_d = PH_SETUP;
        if (accept && empty_mask) rdy_d = 1'b1;
      end
      PH_SETUP: ph_d = PH_ACT;
      PH_ACT:   if (t_last) ph_d = PH_RECOV;
      PH_RECOV: begin
        if (t_last) begin
          ph_d  = PH_IDLE;
          rdy_d = 1'b1;
        end
      end
      default:  ph_d = PH_IDLE;
    endcase
  end

  assign t_load = (ph_q == PH_SETUP) || (ph_q == PH_ACT && t_last);
  always_comb begin
    if (ph_q == PH_SETUP) t_len = cmd_we_q ? CW'(WR_ACT) : CW'(RD_ACT);
    else                  t_len = cmd_we_q ? CW'(WR_REC) : CW'(RD_REC);
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .len  (t_len),
    .last (t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      rdy_q       <= 1'b0;
      cmd_we_q    <= 1'b0;
      cmd_be_q    <= '0;
      cmd_wdata_q <= '0;
    end else begin
      ph_q  <= ph_d;
      rdy_q <= rdy_d;
      if (start) begin
        cmd_we_q    <= host_we;
        cmd_be_q    <= host_be;
        cmd_wdata_q <= host_wdata;
      end
    end
  end

  // read capture on the edge that closes the active phase
  for (genvar g = 0; g < LANES; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata_q[g*8 +: 8] <= '0;
      end else if (ph_q == PH_ACT && t_last && !cmd_we_q) begin
        rdata_q[g*8 +: 8] <= cmd_be_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
      end
    end
  end

  sram_pin_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .nxt_phase (ph_d),
    .cmd_we    (cmd_we_q),
    .cmd_be    (cmd_be_q),
    .cmd_wdata (cmd_wdata_q),
    .addr_load (start),
    .addr_in   (host_addr),
    .addr      (mem_addr),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .lane_n    (lane_n),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe)
  );

  assign mem_ub_n   = lane_n[LANES-1];
  assign mem_lb_n   = lane_n[0];
  assign host_rdy   = rdy_q;
  assign host_rdata = rdata_q;

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n)); // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n); // R2
  AST_DRIVE_ONLY_WE: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !mem_cs_n)); // R4
  AST_ADDR_BEFORE_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cs_n) |-> $stable(mem_addr)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R3
  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    host_rdy |=> !host_rdy); // R7
  AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |=> mem_cs_n); // R9
  AST_CS_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (!mem_ub_n || !mem_lb_n)); // R8

endmodule

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WR_ACT = mx(cyc(55), cyc(35));
  localparam int E_WR_REC = mx(cyc(5), cyc(85) - 1 - E_WR_ACT);
  localparam int E_RD_ACT = mx(cyc(85), cyc(45));
  localparam int E_RD_REC = mx(1, cyc(85) - 1 - E_RD_ACT);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_be = 2'b00;
  logic [19:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_rdy;
  logic [15:0] host_rdata;
  logic [19:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl u_sram_seq_ctrl (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_be(host_be),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdy(host_rdy), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, keyed on the low address byte
  logic [15:0] mdl [256];
  logic [15:0] ref_m [256];

  assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ?
    { (mem_ub_n ? 8'h00 : mdl[mem_addr[7:0]][15:8]),
      (mem_lb_n ? 8'h00 : mdl[mem_addr[7:0]][7:0]) } : 16'h0000;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mdl[i] <= 16'h0000;
    end else if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
    end
  end

  // pin monitor, sampled at the falling edge
  logic [15:0] cur_wdata;
  logic [19:0] cur_addr;
  logic [1:0]  cur_be;
  int  we_run = 0, oe_run = 0, cs_high_run = 0, cs_falls = 0;
  bit  prev_we_n = 1, prev_oe_n = 1, prev_cs_n = 1;
  bit  addr_bad = 0, dq_bad = 0, lane_bad = 0;
  logic [19:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_dq_oe != !mem_we_n) dq_bad = 1;
      if (!mem_we_n && mem_dq_out != cur_wdata) dq_bad = 1;
      if (!mem_cs_n && ({!mem_ub_n, !mem_lb_n} != cur_be)) lane_bad = 1;
      if (!mem_we_n && !mem_oe_n) lane_bad = 1;
      if (!mem_we_n) we_run++;
      if (!mem_oe_n) oe_run++;
      if (mem_we_n && !prev_we_n) begin
        chk(we_run == E_WR_ACT, "R2 write pulse cycles", we_run, E_WR_ACT);
        chk(!dq_bad, "R4 bus drive/data", mem_dq_out, cur_wdata);
        we_run = 0; dq_bad = 0;
      end
      if (mem_oe_n && !prev_oe_n) begin
        chk(oe_run == E_RD_ACT, "R5 read strobe cycles", oe_run, E_RD_ACT);
        oe_run = 0;
      end
      if (!mem_cs_n && prev_cs_n) begin
        cs_falls++;
        chk(cs_high_run >= 1, "R9 idle before strobe", cs_high_run, 1);
        chk(mem_addr == prev_addr && mem_addr == cur_addr, "R3 address set early",
            int'(prev_addr), int'(cur_addr));
        addr_bad = 0;
      end else if (!mem_cs_n && mem_addr != prev_addr) begin
        addr_bad = 1;
      end
      if (mem_cs_n && !prev_cs_n) begin
        chk(!addr_bad, "R3 address held", int'(mem_addr), int'(cur_addr));
        chk(!lane_bad, "R2 lane strobes / output enable", {mem_ub_n, mem_lb_n}, ~cur_be);
        lane_bad = 0;
      end
      cs_high_run = mem_cs_n ? cs_high_run + 1 : 0;
      prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_cs_n = mem_cs_n;
      prev_addr = mem_addr;
    end
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic do_op(input bit w, input logic [1:0] be, input logic [19:0] a,
                       input logic [15:0] d);
    int lat;
    int exp_lat;
    int falls0;
    logic [15:0] exp_rd;
    @(negedge clk);
    cur_wdata = d; cur_addr = a; cur_be = be;
    host_req = 1'b1; host_we = w; host_be = be; host_addr = a; host_wdata = d;
    falls0 = cs_falls;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_rdy && lat < 200);
    if (be == 2'b00) exp_lat = 1;
    else if (w)      exp_lat = 2 + E_WR_ACT + E_WR_REC;
    else             exp_lat = 2 + E_RD_ACT + E_RD_REC;
    if (be == 2'b00) begin
      chk(lat == exp_lat, "R8 empty mask latency", lat, exp_lat);
      chk(cs_falls == falls0, "R8 no strobe on empty mask", cs_falls, falls0);
    end else begin
      chk(lat == exp_lat, "R6 access latency", lat, exp_lat);
    end
    if (!w && be != 2'b00) begin
      exp_rd = ref_m[a[7:0]] & lane_mask(be);
      chk(host_rdata == exp_rd, "R5 read data", host_rdata, exp_rd);
    end
    if (w) ref_m[a[7:0]] = (ref_m[a[7:0]] & ~lane_mask(be)) | (d & lane_mask(be));
    host_req = 1'b0;
    @(negedge clk);
    chk(!host_rdy, "R7 ready one cycle", host_rdy, 0);
  endtask

  task automatic run_all();
    logic [19:0] pool [16];
    for (int i = 0; i < 256; i++) ref_m[i] = 16'h0000;
    for (int i = 0; i < 16; i++) pool[i] = {12'($urandom), 8'(i * 7)};
    cur_wdata = '0; cur_addr = '0; cur_be = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n,
        "R1 strobes idle in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}, 5'h1f);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_dq_oe && !host_rdy && mem_cs_n && mem_we_n && mem_oe_n,
        "R1 state after reset", {mem_dq_oe, host_rdy}, 0);
    // directed corners
    do_op(1, 2'b11, 20'hABC12, 16'h1234);
    do_op(0, 2'b11, 20'hABC12, 16'h0000);
    do_op(1, 2'b10, 20'hABC12, 16'hEE55);
    do_op(0, 2'b11, 20'hABC12, 16'h0000);
    do_op(1, 2'b01, 20'hABC12, 16'h77AA);
    do_op(0, 2'b01, 20'hABC12, 16'h0000);
    do_op(0, 2'b10, 20'hABC12, 16'h0000);
    do_op(1, 2'b00, 20'hABC12, 16'hFFFF);
    do_op(0, 2'b00, 20'hABC12, 16'h0000);
    do_op(0, 2'b11, 20'hABC12, 16'h0000);
    do_op(1, 2'b11, 20'hFFFFF, 16'hFFFF);
    do_op(0, 2'b11, 20'hFFFFF, 16'h0000);
    // constrained random traffic on a small address pool
    for (int k = 0; k < 300; k++) begin
      do_op(1'($urandom), 2'($urandom), pool[$urandom % 16], 16'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'd24681));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule